// File: doc/BRIEF.md
# Edge-Selectable Status Interrupt Unit

This block watches four already-synchronised status lines (host disconnect, VBUS valid, session valid, session end) and raises an event when one of them changes in a direction that software has enabled. Rising and falling changes are enabled separately, through two 8-bit enable registers. Each register is reached through three aliased addresses. One replaces the value, one ORs in the ones of the write data, and one clears the bits that are one in the write data. All three addresses read the current value.

A detected, enabled change produces two results. The first is a single-cycle event pulse, which asks the surrounding logic to send a status-report command. The second is a sticky interrupt with a 4-bit source field that records which lines caused it. Software acknowledges through a dedicated strobe. A new enabled change in the same cycle as the acknowledge takes priority and keeps the interrupt asserted.

Top module: `stat_edge_irq`

## Requirements
- R1: After reset both enable registers read 8'h0F, and `irq_o`, `event_o` and `src_o` are 0. The registered copy of the status lines resets to 0.
- R2: The rise-enable register reads at 8'h0D, 8'h0E and 8'h0F. A write to 8'h0D replaces its value.
- R3: A write to the set alias (8'h0E rise, 8'h11 fall) ORs the write data into the register. A write to the clear alias (8'h0F rise, 8'h12 fall) clears the bits that are 1 in the write data.
- R4: The fall-enable register reads at 8'h10, 8'h11 and 8'h12. A write to 8'h10 replaces its value.
- R5: Bits 7:4 of both registers ignore writes and always read 0.
- R6: Bit positions are shared by `status_i`, both enable registers and `src_o`: bit 0 host disconnect, bit 1 VBUS valid, bit 2 session valid, bit 3 session end.
- R7: A 0-to-1 change on `status_i[n]` with rise-enable bit n set is seen at the clock edge where the new value is first sampled. `event_o` is high for exactly the following cycle, and `irq_o` goes high in that same cycle.
- R8: A 1-to-0 change with fall-enable bit n set behaves as in R7. A change whose direction is not enabled produces no event, no interrupt and no source bit.
- R9: `irq_o` stays high until `ack_i` is sampled high. The acknowledge clears `irq_o` and `src_o`. If an enabled change is seen in the same cycle as the acknowledge, `irq_o` stays high and `src_o` holds only the new sources.
- R10: Several enabled changes seen in one cycle produce one event pulse, and all of them are set in `src_o`. Source bits accumulate across events until they are acknowledged.
- R11: Any read address other than the six register addresses returns 0, and a write to such an address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Register write data |
| we_i | input | 1 | Write strobe |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| status_i | input | 4 | Synchronised status lines |
| ack_i | input | 1 | Interrupt acknowledge strobe |
| irq_o | output | 1 | Sticky interrupt |
| event_o | output | 1 | One-cycle status-report request |
| src_o | output | 4 | Latched interrupt sources |

## Verification
The hardest case to reach is an acknowledge that lands in the same clock cycle as a new enabled change. In that case the new source must survive while the old sources are cleared. The bench sets up the pending interrupt first. It then drives `ack_i` and the status change at the same falling edge, so that both are sampled at one rising edge. Coincident multi-line changes are produced in the same way, by switching several status bits in a single drive.

// File: rtl/stat_edge_irq_pkg.sv
package stat_edge_irq_pkg;
  parameter int unsigned AW   = 8;
  parameter int unsigned DW   = 8;
  parameter int unsigned NSRC = 4;

  parameter logic [AW-1:0] RISE_BASE = 8'h0D;
  parameter logic [AW-1:0] FALL_BASE = 8'h10;

  typedef enum logic [1:0] {
    OP_NONE,
    OP_WR,
    OP_SET,
    OP_CLR
  } reg_op_e;
endpackage

// File: rtl/enable_reg.sv
module enable_reg
  import stat_edge_irq_pkg::*;
#(
  parameter logic [AW-1:0]   BASE  = RISE_BASE,
  parameter logic [NSRC-1:0] RST_V = '1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic            we_i,
  output logic [NSRC-1:0] en_o,
  output logic            hit_o
);
  reg_op_e         op;
  logic [NSRC-1:0] en_q, en_d;
  logic [NSRC-1:0] wd;

  assign wd = wdata_i[NSRC-1:0];

  always_comb begin
    op    = OP_NONE;
    hit_o = 1'b0;
    if (addr_i == BASE) begin
      op = OP_WR; hit_o = 1'b1;
    end else if (addr_i == BASE + AW'(1)) begin
      op = OP_SET; hit_o = 1'b1;
    end else if (addr_i == BASE + AW'(2)) begin
      op = OP_CLR; hit_o = 1'b1;
    end
  end

  always_comb begin
    en_d = en_q;
    if (we_i) begin
      unique case (op)
        OP_WR:   en_d = wd;
        OP_SET:  en_d = en_q | wd;
        OP_CLR:  en_d = en_q & ~wd;
        default: en_d = en_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= RST_V;
    else         en_q <= en_d;
  end

  assign en_o = en_q;
endmodule

// File: rtl/edge_detect.sv
module edge_detect
  import stat_edge_irq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] status_i,
  output logic [NSRC-1:0] prev_o,
  output logic [NSRC-1:0] rise_o,
  output logic [NSRC-1:0] fall_o
);
  logic [NSRC-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= status_i;
  end

  assign prev_o = prev_q;
  assign rise_o = status_i & ~prev_q;
  assign fall_o = ~status_i & prev_q;
endmodule

// File: rtl/stat_edge_irq.sv
module stat_edge_irq
  import stat_edge_irq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic            we_i,
  output logic [DW-1:0]   rdata_o,
  input  logic [NSRC-1:0] status_i,
  input  logic            ack_i,
  output logic            irq_o,
  output logic            event_o,
  output logic [NSRC-1:0] src_o
);
  localparam int unsigned NREG = 2;

  logic [NSRC-1:0] en_w  [NREG];
  logic [NREG-1:0] hit_w;
  logic [NSRC-1:0] prev_w, rise_w, fall_w, fire_w;
  logic            evt_q, irq_q;
  logic [NSRC-1:0] src_q;

  // index 0: rising enables, index 1: falling enables
  for (genvar g = 0; g < NREG; g++) begin : g_en
    enable_reg #(
      .BASE  (g == 0 ? RISE_BASE : FALL_BASE),
      .RST_V ('1)
    ) i_enable_reg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .addr_i  (addr_i),
      .wdata_i (wdata_i),
      .we_i    (we_i),
      .en_o    (en_w[g]),
      .hit_o   (hit_w[g])
    );
  end

  edge_detect i_edge_detect (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .status_i (status_i),
    .prev_o   (prev_w),
    .rise_o   (rise_w),
    .fall_o   (fall_w)
  );

  assign fire_w = (rise_w & en_w[0]) | (fall_w & en_w[1]);

  always_comb begin
    rdata_o = '0;
    if (hit_w[0])      rdata_o[NSRC-1:0] = en_w[0];
    else if (hit_w[1]) rdata_o[NSRC-1:0] = en_w[1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q <= 1'b0;
      irq_q <= 1'b0;
      src_q <= '0;
    end else begin
      evt_q <= |fire_w;
      // new sources win over a coincident acknowledge
      irq_q <= (irq_q & ~ack_i) | (|fire_w);
      src_q <= (ack_i ? '0 : src_q) | fire_w;
    end
  end

  assign event_o = evt_q;
  assign irq_o   = irq_q;
  assign src_o   = src_q;
endmodule

// File: rtl/stat_edge_irq_chk.sv
module stat_edge_irq_chk
  import stat_edge_irq_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic [DW-1:0]   rdata_o,
  input logic [NSRC-1:0] status_i,
  input logic [NSRC-1:0] prev_w,
  input logic            ack_i,
  input logic            irq_o,
  input logic            event_o,
  input logic [NSRC-1:0] src_o
);
  AST_RSV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DW-1:NSRC] == '0); // R5

  AST_EVT_NEEDS_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_o |-> $past(status_i != prev_w)); // R7

  AST_EVT_SETS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_o |-> irq_o); // R7

  AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !ack_i |=> irq_o); // R9

  AST_IRQ_RISE_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> event_o); // R9

  AST_SRC_MATCH_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (src_o != '0)); // R10
endmodule

bind stat_edge_irq stat_edge_irq_chk i_stat_edge_irq_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .rdata_o  (rdata_o),
  .status_i (status_i),
  .prev_w   (prev_w),
  .ack_i    (ack_i),
  .irq_o    (irq_o),
  .event_o  (event_o),
  .src_o    (src_o)
);

// File: tb/test_stat_edge_irq.sv
`timescale 1ns/1ps
module test_stat_edge_irq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = '0, wdata = '0, rdata;
  logic       we = 1'b0, ack = 1'b0;
  logic [3:0] status = '0, src;
  logic       irq, evt;
  int         n_chk = 0, n_err = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  stat_edge_irq i_stat_edge_irq (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .rdata_o(rdata), .status_i(status), .ack_i(ack), .irq_o(irq),
    .event_o(evt), .src_o(src)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk); addr = a; #1;
    check(req, rdata, exp);
  endtask

  // drive status (and optionally ack) at a falling edge; sample one cycle later
  task automatic drive(input logic [3:0] s, input logic a);
    @(negedge clk); status = s; ack = a;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic do_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    check("R9 irq cleared", {7'd0, irq}, 8'h00);
    check("R9 src cleared", {4'd0, src}, 8'h00);
  endtask

  task automatic t_reset();
    check("R1 irq", {7'd0, irq}, 8'h00);
    check("R1 event", {7'd0, evt}, 8'h00);
    check("R1 src", {4'd0, src}, 8'h00);
    for (int a = 8'h0D; a <= 8'h12; a++) rd_chk("R1 R2 R4 reset value", 8'(a), 8'h0F);
  endtask

  task automatic t_rise_access();
    wr(8'h0D, 8'hA5); rd_chk("R2 R5 replace", 8'h0D, 8'h05);
    wr(8'h0E, 8'h0A); rd_chk("R3 rise set", 8'h0F, 8'h0F);
    wr(8'h0F, 8'h03); rd_chk("R3 rise clear", 8'h0E, 8'h0C);
  endtask

  task automatic t_fall_access();
    wr(8'h10, 8'hF0); rd_chk("R4 R5 replace", 8'h12, 8'h00);
    wr(8'h11, 8'h06); rd_chk("R3 fall set", 8'h10, 8'h06);
    wr(8'h12, 8'h02); rd_chk("R3 fall clear", 8'h11, 8'h04);
    rd_chk("R4 rise untouched", 8'h0D, 8'h0C);
  endtask

  task automatic t_unmapped();
    wr(8'h13, 8'hFF); wr(8'h0C, 8'hFF); wr(8'h00, 8'h00);
    rd_chk("R11 read 13h", 8'h13, 8'h00);
    rd_chk("R11 read 0Ch", 8'h0C, 8'h00);
    rd_chk("R11 read FFh", 8'hFF, 8'h00);
    rd_chk("R11 rise kept", 8'h0D, 8'h0C);
    rd_chk("R11 fall kept", 8'h10, 8'h04);
  endtask

  task automatic t_rise_edges();
    drive(4'h1, 1'b0); // host disconnect rise, disabled
    check("R8 disabled rise no event", {7'd0, evt}, 8'h00);
    check("R8 disabled rise no irq", {7'd0, irq}, 8'h00);
    drive(4'h5, 1'b0); // session valid rise, enabled
    check("R7 event pulse", {7'd0, evt}, 8'h01);
    check("R7 irq set", {7'd0, irq}, 8'h01);
    check("R6 src bit2", {4'd0, src}, 8'h04);
    @(negedge clk);
    check("R7 pulse one cycle", {7'd0, evt}, 8'h00);
    check("R9 irq held", {7'd0, irq}, 8'h01);
    do_ack();
  endtask

  task automatic t_fall_edges();
    drive(4'h4, 1'b0); // bit0 falls, disabled
    check("R8 disabled fall no event", {7'd0, evt}, 8'h00);
    check("R8 disabled fall no src", {4'd0, src}, 8'h00);
    drive(4'h0, 1'b0); // bit2 falls, enabled
    check("R8 fall event", {7'd0, evt}, 8'h01);
    check("R8 R6 fall src", {4'd0, src}, 8'h04);
    do_ack();
  endtask

  task automatic t_multi();
    wr(8'h0E, 8'h0F);
    drive(4'hB, 1'b0);
    check("R10 single pulse", {7'd0, evt}, 8'h01);
    check("R10 all sources", {4'd0, src}, 8'h0B);
    @(negedge clk);
    check("R10 pulse ends", {7'd0, evt}, 8'h00);
    repeat (3) @(negedge clk);
    check("R9 irq held without ack", {7'd0, irq}, 8'h01);
    drive(4'hF, 1'b0);
    check("R10 accumulate", {4'd0, src}, 8'h0F);
    do_ack();
  endtask

  task automatic t_ack_collision();
    wr(8'h11, 8'h0F);
    drive(4'h7, 1'b0); // bit3 falls
    check("R9 pre-collision src", {4'd0, src}, 8'h08);
    drive(4'h3, 1'b1); // bit2 falls with ack
    check("R9 collision irq kept", {7'd0, irq}, 8'h01);
    check("R9 collision new src only", {4'd0, src}, 8'h04);
    check("R9 collision event", {7'd0, evt}, 8'h01);
    do_ack();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rise_access();
    t_fall_access();
    t_unmapped();
    t_rise_edges();
    t_fall_edges();
    t_multi();
    t_ack_collision();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule